// File: doc/BRIEF.md
# Epoch Calendar Member Selector

This block picks the destination worker for an accepted packet from the 64-bit event tick carried in that packet. It makes three table lookups in a fixed three-stage pipeline. First, a priority ternary match on the tick selects a 32-bit calendar epoch. Second, that epoch together with the nine low tick bits addresses a weighted calendar that names a 16-bit member. Third, the packet's EtherType together with that member selects a rewrite record: an action code, a next-hop MAC, a destination IP and a destination UDP port. If any stage misses, or the rewrite record does not fit the packet's EtherType, the result is a drop.

Software fills all three tables through one write port. A member that appears in more calendar slots receives a larger share of ticks. A tick keeps the same member for as long as its epoch stays unchanged, so the tables can be reconfigured without disturbing traffic: software builds a new epoch beside the old one and then points the ternary table at it. The block applies a write only when no lookup is in flight. As a result, every packet sees a single, consistent snapshot of the tables.

Top module: `tick_member_select`

## Requirements
- R1: After reset, no response is valid and both the request port and the configuration port report ready.
- R2: An epoch entry matches when the tick equals its value on every bit set in its mask. Among the matching valid entries, the one with the lowest priority number supplies the epoch. On a tie, the lower entry index wins.
- R3: An epoch entry with an all-zero mask matches every tick. A longer-prefix entry with a better priority overrides it within its range; for example, value 0x10 with mask ~0xF covers ticks 0x10 to 0x1F.
- R4: A tick that matches no valid epoch entry produces a drop.
- R5: The calendar slot is tick bits [8:0]. The calendar is an exact match on {epoch, slot} that returns a member ID, and an unpopulated {epoch, slot} produces a drop.
- R6: The member table is an exact match on {EtherType, member ID} that returns an action, MAC, IP and port. On a hit, these values appear on the response together with the member ID; a miss produces a drop.
- R7: Action 1 (IPv4 rewrite) is accepted only with EtherType 0x0800, and action 2 (IPv6 rewrite) only with EtherType 0x86DD. Any other pairing produces a drop.
- R8: A dropped response carries zero in its member, action, MAC, IP and port fields.
- R9: With the response side ready, the response appears three cycles after the request is accepted, and responses keep request order. While the response is not taken, the response and all its fields are held.
- R10: A configuration write is accepted only when the pipeline is empty. While a write is pending, no request is accepted. A write affects only the lookups accepted after it, so a packet already in flight sees the old contents.
- R11: Writing an entry with its valid bit clear removes it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_tick | input | 64 | Event tick of the packet |
| req_etype | input | 16 | EtherType of the packet |
| resp_valid | output | 1 | Lookup result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_drop | output | 1 | Packet is to be discarded |
| resp_member | output | 16 | Selected member ID (zero on drop) |
| resp_action | output | 8 | Rewrite action code, 1 = IPv4, 2 = IPv6 (zero on drop) |
| resp_mac | output | 48 | Next-hop destination MAC (zero on drop) |
| resp_ip | output | 128 | Destination IP; an IPv4 address sits in bits [31:0] (zero on drop) |
| resp_port | output | 16 | Destination UDP port (zero on drop) |
| cfg_wr | input | 1 | Table write request |
| cfg_ready | output | 1 | Write taken on this edge when cfg_wr is high |
| cfg_table | input | 2 | 0 = epoch table, 1 = calendar, 2 = member table |
| cfg_addr | input | 16 | Entry index; an index beyond the table depth is ignored |
| cfg_entry_valid | input | 1 | Valid bit written into the entry |
| cfg_key_hi | input | 64 | Epoch: match value; calendar: epoch in [31:0]; member: EtherType in [15:0] |
| cfg_key_lo | input | 64 | Epoch: care mask; calendar: slot in [8:0]; member: member ID in [15:0] |
| cfg_prio | input | 8 | Epoch entry priority, lower wins |
| cfg_res | input | 32 | Epoch: epoch value; calendar: member ID in [15:0]; member: action in [7:0] |
| cfg_mac | input | 48 | Member: next-hop MAC |
| cfg_ip | input | 128 | Member: destination IP |
| cfg_port | input | 16 | Member: destination UDP port |

## Verification
The bench builds the block with four epoch entries, sixteen calendar entries and eight member entries. These are small depths, but each is enough to hold a wildcard epoch, a /60 range, an exact entry and a /56 entry that overlap, as well as populated and empty slots in several epochs, and member records whose action both fits and mismatches the EtherType. With these depths, priority override, slot wrap at bit 9, invalidation, and a write held back behind an in-flight packet can all be reached in a few dozen cycles.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int TICK_W   = 64;
    localparam int EPOCH_W  = 32;
    localparam int SLOT_W   = 9;
    localparam int MEMBER_W = 16;
    localparam int ETYPE_W  = 16;
    localparam int ACT_W    = 8;
    localparam int MAC_W    = 48;
    localparam int IP_W     = 128;
    localparam int PORT_W   = 16;
    localparam int PRIO_W   = 8;

    localparam logic [ETYPE_W-1:0] ET_IPV4 = 16'h0800;
    localparam logic [ETYPE_W-1:0] ET_IPV6 = 16'h86DD;
    localparam logic [ACT_W-1:0]   ACT_V4  = 8'd1;
    localparam logic [ACT_W-1:0]   ACT_V6  = 8'd2;

    typedef enum logic [1:0] {
        TBL_EPOCH  = 2'd0,
        TBL_CAL    = 2'd1,
        TBL_MEMBER = 2'd2
    } tbl_sel_e;

    typedef struct packed {
        logic [ACT_W-1:0]  act;
        logic [MAC_W-1:0]  mac;
        logic [IP_W-1:0]   ip;
        logic [PORT_W-1:0] port;
    } rewrite_t;

    localparam int RW_W = $bits(rewrite_t);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [ETYPE_W-1:0] etype;
        logic               hit;
        logic [EPOCH_W-1:0] epoch;
    } stg1_t;

    typedef struct packed {
        logic [ETYPE_W-1:0]  etype;
        logic                hit;
        logic [MEMBER_W-1:0] member;
    } stg2_t;

    typedef struct packed {
        logic                drop;
        logic [MEMBER_W-1:0] member;
        rewrite_t            rw;
    } stg3_t;

    function automatic logic action_fits(input logic [ETYPE_W-1:0] et,
                                         input logic [ACT_W-1:0] act);
        return (et == ET_IPV4 && act == ACT_V4) || (et == ET_IPV6 && act == ACT_V6);
    endfunction

endpackage

// File: rtl/tms_epoch_tcam.sv
module tms_epoch_tcam
    import tms_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic               wr_valid,
    input  logic [TICK_W-1:0]  wr_value,
    input  logic [TICK_W-1:0]  wr_mask,
    input  logic [PRIO_W-1:0]  wr_prio,
    input  logic [EPOCH_W-1:0] wr_epoch,
    input  logic [TICK_W-1:0]  key,
    output logic               hit,
    output logic [EPOCH_W-1:0] epoch
);
    logic [DEPTH-1:0]   vld_q;
    logic [TICK_W-1:0]  val_q [DEPTH];
    logic [TICK_W-1:0]  msk_q [DEPTH];
    logic [PRIO_W-1:0]  pri_q [DEPTH];
    logic [EPOCH_W-1:0] ep_q  [DEPTH];
    logic [DEPTH-1:0]   match;

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_valid;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_q[wr_idx] <= wr_value;
            msk_q[wr_idx] <= wr_mask;
            pri_q[wr_idx] <= wr_prio;
            ep_q[wr_idx]  <= wr_epoch;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (((key ^ val_q[g]) & msk_q[g]) == '0);
    end

    always_comb begin
        logic [PRIO_W-1:0] best;
        hit   = 1'b0;
        epoch = '0;
        best  = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i] && (!hit || pri_q[i] < best)) begin
                hit   = 1'b1;
                best  = pri_q[i];
                epoch = ep_q[i];
            end
        end
    end
endmodule

// File: rtl/tms_exact_cam.sv
module tms_exact_cam #(
    parameter int DEPTH = 32,
    parameter int KEY_W = 16,
    parameter int RES_W = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [RES_W-1:0] wr_res,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [RES_W-1:0] res
);
    logic [DEPTH-1:0] vld_q;
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [RES_W-1:0] res_q [DEPTH];
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_valid;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx] <= wr_key;
            res_q[wr_idx] <= wr_res;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (key_q[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        res = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                res = res_q[i];
            end
        end
    end
endmodule

// File: rtl/tick_member_select.sv
module tick_member_select
    import tms_pkg::*;
#(
    parameter int EPOCH_DEPTH  = 16,
    parameter int CAL_DEPTH    = 64,
    parameter int MEMBER_DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [63:0]   req_tick,
    input  logic [15:0]   req_etype,
    output logic          resp_valid,
    input  logic          resp_ready,
    output logic          resp_drop,
    output logic [15:0]   resp_member,
    output logic [7:0]    resp_action,
    output logic [47:0]   resp_mac,
    output logic [127:0]  resp_ip,
    output logic [15:0]   resp_port,
    input  logic          cfg_wr,
    output logic          cfg_ready,
    input  logic [1:0]    cfg_table,
    input  logic [15:0]   cfg_addr,
    input  logic          cfg_entry_valid,
    input  logic [63:0]   cfg_key_hi,
    input  logic [63:0]   cfg_key_lo,
    input  logic [7:0]    cfg_prio,
    input  logic [31:0]   cfg_res,
    input  logic [47:0]   cfg_mac,
    input  logic [127:0]  cfg_ip,
    input  logic [15:0]   cfg_port
);
    localparam int EP_IW  = (EPOCH_DEPTH  > 1) ? $clog2(EPOCH_DEPTH)  : 1;
    localparam int CAL_IW = (CAL_DEPTH    > 1) ? $clog2(CAL_DEPTH)    : 1;
    localparam int MEM_IW = (MEMBER_DEPTH > 1) ? $clog2(MEMBER_DEPTH) : 1;
    localparam logic [15:0] EP_LIM  = 16'(EPOCH_DEPTH);
    localparam logic [15:0] CAL_LIM = 16'(CAL_DEPTH);
    localparam logic [15:0] MEM_LIM = 16'(MEMBER_DEPTH);
    localparam int CAL_KW = EPOCH_W + SLOT_W;
    localparam int MEM_KW = ETYPE_W + MEMBER_W;

    logic s1_v, s2_v, s3_v;
    stg1_t s1_q;
    stg2_t s2_q;
    stg3_t s3_q;

    logic advance, pipe_empty, cfg_fire;
    logic we_ep, we_cal, we_mem;

    assign advance    = !s3_v || resp_ready;
    assign pipe_empty = !s1_v && !s2_v && !s3_v;
    assign cfg_ready  = !rst && pipe_empty;
    assign req_ready  = !rst && advance && !cfg_wr;
    assign cfg_fire   = cfg_wr && cfg_ready;

    assign we_ep  = cfg_fire && (tbl_sel_e'(cfg_table) == TBL_EPOCH)  && (cfg_addr < EP_LIM);
    assign we_cal = cfg_fire && (tbl_sel_e'(cfg_table) == TBL_CAL)    && (cfg_addr < CAL_LIM);
    assign we_mem = cfg_fire && (tbl_sel_e'(cfg_table) == TBL_MEMBER) && (cfg_addr < MEM_LIM);

    // Stage 1: priority ternary match on the tick
    logic               ep_hit;
    logic [EPOCH_W-1:0] ep_val;

    tms_epoch_tcam #(.DEPTH(EPOCH_DEPTH)) u_epoch (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (we_ep),
        .wr_idx   (cfg_addr[EP_IW-1:0]),
        .wr_valid (cfg_entry_valid),
        .wr_value (cfg_key_hi),
        .wr_mask  (cfg_key_lo),
        .wr_prio  (cfg_prio),
        .wr_epoch (cfg_res),
        .key      (req_tick),
        .hit      (ep_hit),
        .epoch    (ep_val)
    );

    // Stage 2: weighted calendar on {epoch, slot}
    logic                cal_hit;
    logic [MEMBER_W-1:0] cal_member;

    tms_exact_cam #(.DEPTH(CAL_DEPTH), .KEY_W(CAL_KW), .RES_W(MEMBER_W)) u_cal (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (we_cal),
        .wr_idx   (cfg_addr[CAL_IW-1:0]),
        .wr_valid (cfg_entry_valid),
        .wr_key   ({cfg_key_hi[EPOCH_W-1:0], cfg_key_lo[SLOT_W-1:0]}),
        .wr_res   (cfg_res[MEMBER_W-1:0]),
        .key      ({s1_q.epoch, s1_q.slot}),
        .hit      (cal_hit),
        .res      (cal_member)
    );

    // Stage 3: member rewrite record on {EtherType, member}
    logic            mem_hit;
    logic [RW_W-1:0] mem_raw;
    rewrite_t        mem_rw;
    logic            s3_hit;

    tms_exact_cam #(.DEPTH(MEMBER_DEPTH), .KEY_W(MEM_KW), .RES_W(RW_W)) u_member (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (we_mem),
        .wr_idx   (cfg_addr[MEM_IW-1:0]),
        .wr_valid (cfg_entry_valid),
        .wr_key   ({cfg_key_hi[ETYPE_W-1:0], cfg_key_lo[MEMBER_W-1:0]}),
        .wr_res   ({cfg_res[ACT_W-1:0], cfg_mac, cfg_ip, cfg_port}),
        .key      ({s2_q.etype, s2_q.member}),
        .hit      (mem_hit),
        .res      (mem_raw)
    );

    assign mem_rw = rewrite_t'(mem_raw);
    assign s3_hit = s2_q.hit && mem_hit && action_fits(s2_q.etype, mem_rw.act);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else if (advance) begin
            s1_v <= req_valid && req_ready;
            s2_v <= s1_v;
            s3_v <= s2_v;
        end
    end

    always_ff @(posedge clk) begin
        if (advance) begin
            s1_q.slot   <= req_tick[SLOT_W-1:0];
            s1_q.etype  <= req_etype;
            s1_q.hit    <= ep_hit;
            s1_q.epoch  <= ep_val;
            s2_q.etype  <= s1_q.etype;
            s2_q.hit    <= s1_q.hit && cal_hit;
            s2_q.member <= cal_member;
            s3_q.drop   <= !s3_hit;
            s3_q.member <= s3_hit ? s2_q.member : '0;
            s3_q.rw     <= s3_hit ? mem_rw : '0;
        end
    end

    assign resp_valid  = s3_v;
    assign resp_drop   = s3_q.drop;
    assign resp_member = s3_q.member;
    assign resp_action = s3_q.rw.act;
    assign resp_mac    = s3_q.rw.mac;
    assign resp_ip     = s3_q.rw.ip;
    assign resp_port   = s3_q.rw.port;
endmodule

// File: rtl/tms_checker.sv
module tms_checker (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic         resp_valid,
    input logic         resp_ready,
    input logic         resp_drop,
    input logic [15:0]  resp_member,
    input logic [7:0]   resp_action,
    input logic [47:0]  resp_mac,
    input logic [127:0] resp_ip,
    input logic [15:0]  resp_port,
    input logic         cfg_wr,
    input logic         cfg_ready
);
    AST_DROP_ZEROED: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_drop |-> resp_member == '0 && resp_action == '0 && resp_mac == '0 && resp_ip == '0 && resp_port == '0); // R8

    AST_ACTION_LEGAL: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_drop |-> resp_action == 8'd1 || resp_action == 8'd2); // R7

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_ready, 3) && $past(resp_ready, 2) && $past(resp_ready, 1) |-> resp_valid); // R9

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_drop) && $stable(resp_member) && $stable(resp_port) && $stable(resp_ip)); // R9

    AST_WRITE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> !req_ready); // R10

    AST_WRITE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_ready |=> !resp_valid); // R10
endmodule

bind tick_member_select tms_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_ready  (resp_ready),
    .resp_drop   (resp_drop),
    .resp_member (resp_member),
    .resp_action (resp_action),
    .resp_mac    (resp_mac),
    .resp_ip     (resp_ip),
    .resp_port   (resp_port),
    .cfg_wr      (cfg_wr),
    .cfg_ready   (cfg_ready)
);

// File: tb/tick_member_select_bench.sv
module tick_member_select_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         req_valid = 1'b0, req_ready;
    logic [63:0]  req_tick = '0;
    logic [15:0]  req_etype = '0;
    logic         resp_valid, resp_ready = 1'b1, resp_drop;
    logic [15:0]  resp_member, resp_port;
    logic [7:0]   resp_action;
    logic [47:0]  resp_mac;
    logic [127:0] resp_ip;
    logic         cfg_wr = 1'b0, cfg_ready, cfg_entry_valid = 1'b0;
    logic [1:0]   cfg_table = '0;
    logic [15:0]  cfg_addr = '0, cfg_port = '0;
    logic [63:0]  cfg_key_hi = '0, cfg_key_lo = '0;
    logic [7:0]   cfg_prio = '0;
    logic [31:0]  cfg_res = '0;
    logic [47:0]  cfg_mac = '0;
    logic [127:0] cfg_ip = '0;

    tick_member_select #(.EPOCH_DEPTH(4), .CAL_DEPTH(16), .MEMBER_DEPTH(8)) u_tick_member_select (.*);

    localparam logic [47:0]  M1 = 48'h1122_3344_5566, M2 = 48'h0A0B_0C0D_0E0F, M3 = 48'h6655_4433_2211;
    localparam logic [127:0] IP1 = 128'hAABB_CCDD, IP2 = 128'hFE80_0000_0000_0000_0000_0000_0000_0003,
                             IP3 = 128'h0A00_0009;
    localparam logic [15:0]  P1 = 16'h4556, P2 = 16'h1234, P3 = 16'h5000, ET4 = 16'h0800, ET6 = 16'h86DD;

    typedef struct {
        string        tag;
        bit           drop;
        logic [15:0]  member;
        logic [7:0]   act;
        logic [47:0]  mac;
        logic [127:0] ip;
        logic [15:0]  port;
        int           acc;
        bit           lat;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0, checks = 0, cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input string got, input string want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %s expected %s", what, got, want);
        end
    endtask

    // monitor: compares each taken response against the scoreboard head
    always @(negedge clk) begin
        #1;
        if (!rst && resp_valid && resp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", "response", "none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(resp_drop == e.drop && resp_member == e.member && resp_action == e.act &&
                      resp_mac == e.mac && resp_ip == e.ip && resp_port == e.port, e.tag,
                      $sformatf("drop=%0d mem=%h act=%h mac=%h ip=%h port=%h",
                                resp_drop, resp_member, resp_action, resp_mac, resp_ip, resp_port),
                      $sformatf("drop=%0d mem=%h act=%h mac=%h ip=%h port=%h",
                                e.drop, e.member, e.act, e.mac, e.ip, e.port));
                if (e.lat)
                    check(cyc - e.acc == 3, {e.tag, " R9 latency"},
                          $sformatf("%0d", cyc - e.acc), "3");
            end
        end
    end

    task automatic send(input logic [63:0] t, input logic [15:0] et, input string tag,
                        input bit drop, input logic [15:0] mem, input logic [7:0] act,
                        input logic [47:0] mac, input logic [127:0] ip, input logic [15:0] port,
                        input bit lat, input bit keep);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_tick = t; req_etype = et;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        e.tag = tag; e.drop = drop; e.member = mem; e.act = act; e.mac = mac;
        e.ip = ip; e.port = port; e.acc = cyc; e.lat = lat;
        exp_q.push_back(e);
        @(posedge clk);
        if (!keep) begin @(negedge clk); req_valid = 1'b0; end
    endtask

    task automatic send_drop(input logic [63:0] t, input logic [15:0] et, input string tag,
                             input bit lat);
        send(t, et, tag, 1'b1, '0, '0, '0, '0, '0, lat, 1'b0);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] addr, input bit v,
                             input logic [63:0] khi, input logic [63:0] klo, input logic [7:0] pr,
                             input logic [31:0] res, input logic [47:0] mac,
                             input logic [127:0] ip, input logic [15:0] port);
        @(negedge clk);
        cfg_table = sel; cfg_addr = addr; cfg_entry_valid = v; cfg_key_hi = khi; cfg_key_lo = klo;
        cfg_prio = pr; cfg_res = res; cfg_mac = mac; cfg_ip = ip; cfg_port = port; cfg_wr = 1'b1;
        #1;
        while (!cfg_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 100) begin @(negedge clk); n++; end
        #2;
        check(exp_q.size() == 0, "R9 all responses delivered", $sformatf("%0d left", exp_q.size()), "0 left");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle after reset
        check(resp_valid == 1'b0, "R1 resp_valid after reset", $sformatf("%0d", resp_valid), "0");
        check(req_ready == 1'b1, "R1 req_ready after reset", $sformatf("%0d", req_ready), "1");
        check(cfg_ready == 1'b1, "R1 cfg_ready after reset", $sformatf("%0d", cfg_ready), "1");

        // epoch entries: wildcard, /60 at 0x10, exact 0x100A, /56 at 0x1000
        cfg_write(2'd0, 16'd0, 1'b1, 64'h0, 64'h0, 8'd64, 32'd0, '0, '0, '0);
        cfg_write(2'd0, 16'd1, 1'b1, 64'h10, ~64'hF, 8'd5, 32'd1, '0, '0, '0);
        cfg_write(2'd0, 16'd2, 1'b1, 64'h100A, ~64'h0, 8'd10, 32'd2, '0, '0, '0);
        cfg_write(2'd0, 16'd3, 1'b1, 64'h1000, ~64'hFF, 8'd3, 32'd3, '0, '0, '0);
        // calendar
        cfg_write(2'd1, 16'd0, 1'b1, 64'd0, 64'h0A, 8'd0, 32'd7, '0, '0, '0);
        cfg_write(2'd1, 16'd1, 1'b1, 64'd1, 64'h14, 8'd0, 32'd7, '0, '0, '0);
        cfg_write(2'd1, 16'd2, 1'b1, 64'd0, 64'h1A, 8'd0, 32'd9, '0, '0, '0);
        cfg_write(2'd1, 16'd3, 1'b1, 64'd3, 64'h0A, 8'd0, 32'd9, '0, '0, '0);
        cfg_write(2'd1, 16'd4, 1'b1, 64'd2, 64'h0A, 8'd0, 32'd7, '0, '0, '0);
        // members
        cfg_write(2'd2, 16'd0, 1'b1, {48'd0, ET4}, 64'd7, 8'd0, 32'd1, M1, IP1, P1);
        cfg_write(2'd2, 16'd1, 1'b1, {48'd0, ET6}, 64'd7, 8'd0, 32'd2, M2, IP2, P2);
        cfg_write(2'd2, 16'd2, 1'b1, {48'd0, ET4}, 64'd9, 8'd0, 32'd1, M3, IP3, P3);
        cfg_write(2'd2, 16'd3, 1'b1, {48'd0, ET6}, 64'd9, 8'd0, 32'd1, M3, IP3, P3);

        send(64'h0A, ET4, "R6 IPv4 hit via wildcard epoch", 1'b0, 16'd7, 8'd1, M1, IP1, P1, 1'b1, 1'b0);
        send(64'h14, ET6, "R3 /60 range epoch IPv6 hit", 1'b0, 16'd7, 8'd2, M2, IP2, P2, 1'b1, 1'b0);
        send(64'h20A, ET4, "R5 slot uses tick bits 8:0", 1'b0, 16'd7, 8'd1, M1, IP1, P1, 1'b0, 1'b0);
        send_drop(64'h0B, ET4, "R5 empty calendar slot drops R8", 1'b1);
        send_drop(64'h1A, ET4, "R3 /60 overrides wildcard", 1'b0);
        send(64'h100A, ET4, "R2 lowest priority number wins", 1'b0, 16'd9, 8'd1, M3, IP3, P3, 1'b0, 1'b0);
        send_drop(64'h100A, ET6, "R7 action mismatch drops", 1'b0);
        send_drop(64'h0A, 16'h0806, "R6 member miss drops", 1'b0);
        drain();

        // R9: back-to-back burst under backpressure
        @(negedge clk); resp_ready = 1'b0;
        send(64'h0A, ET4, "R9 burst order 1", 1'b0, 16'd7, 8'd1, M1, IP1, P1, 1'b0, 1'b1);
        send(64'h14, ET6, "R9 burst order 2", 1'b0, 16'd7, 8'd2, M2, IP2, P2, 1'b0, 1'b1);
        send_drop(64'h0B, ET4, "R9 burst order 3", 1'b0);
        repeat (3) @(negedge clk);
        #1;
        begin
            logic [15:0] held;
            held = resp_member;
            check(resp_valid == 1'b1 && req_ready == 1'b0, "R9 full pipe stalls",
                  $sformatf("v=%0d rdy=%0d", resp_valid, req_ready), "v=1 rdy=0");
            repeat (2) @(negedge clk);
            #1;
            check(resp_valid == 1'b1 && resp_member == held && resp_port == P1, "R9 held under stall",
                  $sformatf("v=%0d mem=%h port=%h", resp_valid, resp_member, resp_port),
                  $sformatf("v=1 mem=%h port=%h", held, P1));
        end
        @(negedge clk); resp_ready = 1'b1;
        drain();

        // R10: write held behind in-flight packet; packet sees old record
        send(64'h0A, ET4, "R10 in-flight keeps old record", 1'b0, 16'd7, 8'd1, M1, IP1, P1, 1'b0, 1'b0);
        cfg_table = 2'd2; cfg_addr = 16'd0; cfg_entry_valid = 1'b1; cfg_key_hi = {48'd0, ET4};
        cfg_key_lo = 64'd7; cfg_res = 32'd1; cfg_mac = M1; cfg_ip = IP1; cfg_port = 16'h7777;
        cfg_wr = 1'b1;
        #1;
        check(req_ready == 1'b0 && cfg_ready == 1'b0, "R10 pending write blocks and waits",
              $sformatf("req_rdy=%0d cfg_rdy=%0d", req_ready, cfg_ready), "req_rdy=0 cfg_rdy=0");
        while (!cfg_ready) begin @(negedge clk); #1; end
        @(negedge clk); cfg_wr = 1'b0;
        send(64'h0A, ET4, "R10 later lookup sees new port", 1'b0, 16'd7, 8'd1, M1, IP1, 16'h7777, 1'b0, 1'b0);
        drain();

        // R11 / R4: invalidate wildcard, tick outside all other entries misses
        cfg_write(2'd0, 16'd0, 1'b0, 64'h0, 64'h0, 8'd64, 32'd0, '0, '0, '0);
        send_drop(64'h0A, ET4, "R11 invalidated entry R4 epoch miss drops", 1'b0);
        send(64'h14, ET6, "R11 other entries still match", 1'b0, 16'd7, 8'd2, M2, IP2, P2, 1'b0, 1'b0);
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule